// File: doc/BRIEF.md
# External Bus Access Timing Sequencer

This block turns single read or write requests from an on-chip host into strobe sequences on an asynchronous external memory bus that is split into eight chip-select zones. Every access runs through three phases: lead, active and trail. Each phase lasts a number of bus timing clock cycles that is programmed separately for each zone and for each direction. A zone can also let the external ready pin stretch the active phase with wait states.

Settings that the external bus cannot honour are clamped to the nearest legal length and reported on an error output. These are a write trail of zero, a write lead below the device minimum, and a read active field below its minimum. A bank register names one zone and an idle count. When the access that follows an access to that zone targets a different zone, the block holds the bus idle for that many cycles first. This gives slow devices in the bank zone time to release the bus.

The host holds a request until a one-cycle acknowledge. The block latches one request at a time. Configuration is written through a simple write port.

Top module: `ebus_seq`

## Requirements
- R1: After reset all chip selects, the read strobe and the write strobe are high, acknowledge is low, error flags are zero and the data output enable is low. Every zone register resets to all ones. The bank register resets to zone 7, idle count 3 and no zone ready-enabled.
- R2: Writing `cfg_wdata` with `cfg_addr` 0..7 loads that zone's timing word. Its fields are: bits 15:13 write lead, 12:10 write active, 9:8 write trail, 7:5 read lead, 4:2 read active, 1:0 read trail.
- R3: A read holds the zone's `bus_cs_n` bit low through lead, active and trail. Lead lasts max(read lead, 1) cycles with both strobes high. `bus_rd_n` is low for max(read active, 5) + 1 + wait-state cycles. Trail lasts max(read trail, 1) cycles.
- R4: A write uses lead = max(write lead, 3) cycles, `bus_wr_n` low for max(write active, 1) + wait-state cycles, and trail = max(write trail, 1) cycles. `bus_oe` is high and `bus_dout` equals the request data on every chip-select cycle of a write; `bus_oe` is low during reads.
- R5: A write trail field of 0 produces a one-cycle trail and sets error bit 2.
- R6: A write lead field below 3 is stretched to 3 cycles and sets error bit 1.
- R7: A read active field below 5 is treated as 5 and sets error bit 0.
- R8: `bus_din` is captured on the last read-active cycle and is presented on `host_rdata` while acknowledge is high.
- R9: A zone whose ready-enable bit is set (bank word bits 13:6, bit 6+zone) gains one wait state per cycle while `bus_ready` is low at the end of the active phase, with at most 7 wait states. A zone whose ready-enable bit is clear ignores `bus_ready`.
- R10: `ack` is high for exactly one cycle after the last trail cycle, with all chip selects high. A request that is held during an access starts no second access before that pulse.
- R11: Address 8 loads the bank word: bits 2:0 bank zone, bits 5:3 idle count. When the previous access used the bank zone and the new one uses another zone, the chip selects stay high for exactly the idle count of cycles before the lead phase.
- R12: No idle cycles are added when the previous access was in a different zone from the bank zone, when the zone repeats, or when the idle count is 0.
- R13: `err_flags` shows the checks of the most recently accepted access and is replaced at every acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus timing clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | 0..7 zone timing word, 8 bank word |
| cfg_wdata | input | 16 | Configuration write data |
| req_valid | input | 1 | Host request, held until acknowledge |
| req_write | input | 1 | 1 write, 0 read |
| req_zone | input | 3 | Target zone |
| req_wdata | input | 16 | Write data |
| ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 16 | Captured read data |
| err_flags | output | 3 | bit0 read active short, bit1 write lead short, bit2 write trail zero |
| bus_cs_n | output | 8 | Active-low chip select per zone |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_oe | output | 1 | Data output enable |
| bus_dout | output | 16 | Data driven on writes |
| bus_din | input | 16 | Data returned on reads |
| bus_ready | input | 1 | External ready, low requests wait states |

## Verification
The assertions check the following on every cycle: at most one chip select is low, no strobe is low unless a chip select is, the two strobes are never low together, acknowledge lasts one cycle and the bus is idle during it, a capped wait counter always leaves the active phase, write leads are never shorter than the minimum, and the bank register reset and write behaviour. Only the bench scenarios can show the exact phase lengths for each field value, the clamping and error reporting, the data capture, and the wait-state count under ready low. The same holds for whether the idle gap appears or stays away across sequences of zone changes into and out of the bank zone.

// File: rtl/ebus_pkg.sv
`timescale 1ns/1ps
package ebus_pkg;
    localparam int NZ          = 8;
    localparam int ZW          = $clog2(NZ);
    localparam int AW          = ZW + 1;
    localparam int LEN_W       = 3;
    localparam int TRL_W       = 2;
    localparam int GAP_W       = 3;
    localparam int CNT_W       = LEN_W + 1;
    localparam int WAIT_MAX    = 7;
    localparam int WAIT_W      = $clog2(WAIT_MAX + 1);
    localparam int WR_LEAD_MIN = 3;
    localparam int RD_ACT_MIN  = 5;
    localparam int CFG_W       = 2 * (2 * LEN_W + TRL_W);
    localparam int BANK_W      = NZ + GAP_W + ZW;

    typedef struct packed {
        logic [LEN_W-1:0] lead;
        logic [LEN_W-1:0] active;
        logic [TRL_W-1:0] trail;
    } phase_fields_t;

    typedef struct packed {
        phase_fields_t wr;
        phase_fields_t rd;
    } zone_cfg_t;

    typedef struct packed {
        logic [NZ-1:0]    rdy_en;
        logic [GAP_W-1:0] gap;
        logic [ZW-1:0]    zone;
    } bank_cfg_t;

    typedef struct packed {
        logic [CNT_W-1:0] lead;
        logic [CNT_W-1:0] active;
        logic [CNT_W-1:0] trail;
        logic             rdy_en;
    } phase_plan_t;

    typedef struct packed {
        logic trail_zero;
        logic lead_short;
        logic act_short;
    } cfg_err_t;

    typedef enum logic [2:0] {
        S_IDLE, S_GAP, S_LEAD, S_ACT, S_TRAIL, S_ACK
    } seq_state_t;

    localparam zone_cfg_t ZONE_RST = '1;
    localparam bank_cfg_t BANK_RST = '{rdy_en: '0, gap: GAP_W'(3), zone: ZW'(NZ - 1)};

    function automatic logic [CNT_W-1:0] at_least(input logic [CNT_W-1:0] v,
                                                  input logic [CNT_W-1:0] lo);
        return (v < lo) ? lo : v;
    endfunction
endpackage

// File: rtl/ebus_cfg_regs.sv
`timescale 1ns/1ps
module ebus_cfg_regs import ebus_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic [ZW-1:0]    sel_zone,
    output zone_cfg_t        sel_cfg,
    output bank_cfg_t        bank
);
    zone_cfg_t zone_q [NZ];
    bank_cfg_t bank_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NZ; i++) zone_q[i] <= ZONE_RST;
        end else if (cfg_we && cfg_addr < AW'(NZ)) begin
            zone_q[cfg_addr[ZW-1:0]] <= zone_cfg_t'(cfg_wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= BANK_RST;
        end else if (cfg_we && cfg_addr == AW'(NZ)) begin
            bank_q <= bank_cfg_t'(cfg_wdata[BANK_W-1:0]);
        end
    end

    assign sel_cfg = zone_q[sel_zone];
    assign bank    = bank_q;

    // R1: bank register comes out of reset on the top zone
    a_r1_bank_default: assert property (@(posedge clk)
        rst |=> (bank_q == BANK_RST));

    // R11: bank word write lands in the register
    a_r11_bank_write: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == AW'(NZ)) |=> (bank_q == $past(cfg_wdata[BANK_W-1:0])));
endmodule

// File: rtl/ebus_phase_calc.sv
`timescale 1ns/1ps
module ebus_phase_calc import ebus_pkg::*; (
    input  zone_cfg_t   cfg,
    input  logic        is_write,
    input  logic        rdy_en,
    output phase_plan_t plan,
    output cfg_err_t    err
);
    always_comb begin
        plan        = '0;
        err         = '0;
        plan.rdy_en = rdy_en;
        if (is_write) begin
            plan.lead      = at_least(CNT_W'(cfg.wr.lead), CNT_W'(WR_LEAD_MIN));
            plan.active    = at_least(CNT_W'(cfg.wr.active), CNT_W'(1));
            plan.trail     = at_least(CNT_W'(cfg.wr.trail), CNT_W'(1));
            err.lead_short = cfg.wr.lead < LEN_W'(WR_LEAD_MIN);
            err.trail_zero = cfg.wr.trail == '0;
        end else begin
            plan.lead      = at_least(CNT_W'(cfg.rd.lead), CNT_W'(1));
            plan.active    = at_least(CNT_W'(cfg.rd.active), CNT_W'(RD_ACT_MIN)) + CNT_W'(1);
            plan.trail     = at_least(CNT_W'(cfg.rd.trail), CNT_W'(1));
            err.act_short  = cfg.rd.active < LEN_W'(RD_ACT_MIN);
        end
    end
endmodule

// File: rtl/ebus_phase_fsm.sv
`timescale 1ns/1ps
module ebus_phase_fsm import ebus_pkg::*; #(
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [ZW-1:0]    req_zone,
    input  logic [DW-1:0]    req_wdata,
    input  phase_plan_t      plan,
    input  cfg_err_t         plan_err,
    input  logic [ZW-1:0]    bank_zone,
    input  logic [GAP_W-1:0] bank_gap,
    input  logic             bus_ready,
    input  logic [DW-1:0]    bus_din,
    output logic             ack,
    output logic [DW-1:0]    host_rdata,
    output cfg_err_t         err,
    output logic [NZ-1:0]    cs_n,
    output logic             rd_n,
    output logic             wr_n,
    output logic             bus_oe,
    output logic [DW-1:0]    bus_dout
);
    seq_state_t        state;
    logic [CNT_W-1:0]  cnt;
    logic [WAIT_W-1:0] wait_cnt;
    logic [ZW-1:0]     cur_zone;
    logic [ZW-1:0]     prev_zone;
    logic              prev_valid;
    logic              cur_write;
    phase_plan_t       plan_q;
    cfg_err_t          err_q;
    logic [DW-1:0]     wdata_q;
    logic [DW-1:0]     rdata_q;
    logic              gap_needed;
    logic              on_bus;
    logic              extend;

    // leaving the bank zone for another zone costs the programmed idle count
    assign gap_needed = prev_valid && (prev_zone == bank_zone) &&
                        (req_zone != prev_zone) && (bank_gap != '0);
    assign extend     = plan_q.rdy_en && !bus_ready && (wait_cnt < WAIT_W'(WAIT_MAX));

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            cnt        <= '0;
            wait_cnt   <= '0;
            cur_zone   <= '0;
            prev_zone  <= '0;
            prev_valid <= 1'b0;
            cur_write  <= 1'b0;
            plan_q     <= '0;
            err_q      <= '0;
            wdata_q    <= '0;
            rdata_q    <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        cur_zone   <= req_zone;
                        cur_write  <= req_write;
                        wdata_q    <= req_wdata;
                        plan_q     <= plan;
                        err_q      <= plan_err;
                        prev_zone  <= req_zone;
                        prev_valid <= 1'b1;
                        wait_cnt   <= '0;
                        if (gap_needed) begin
                            state <= S_GAP;
                            cnt   <= CNT_W'(bank_gap) - CNT_W'(1);
                        end else begin
                            state <= S_LEAD;
                            cnt   <= plan.lead - CNT_W'(1);
                        end
                    end
                end
                S_GAP: begin
                    if (cnt == '0) begin
                        state <= S_LEAD;
                        cnt   <= plan_q.lead - CNT_W'(1);
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                S_LEAD: begin
                    if (cnt == '0) begin
                        state <= S_ACT;
                        cnt   <= plan_q.active - CNT_W'(1);
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                S_ACT: begin
                    if (cnt != '0) begin
                        cnt <= cnt - CNT_W'(1);
                    end else if (extend) begin
                        wait_cnt <= wait_cnt + WAIT_W'(1);
                    end else begin
                        if (!cur_write) rdata_q <= bus_din;
                        state <= S_TRAIL;
                        cnt   <= plan_q.trail - CNT_W'(1);
                    end
                end
                S_TRAIL: begin
                    if (cnt == '0) begin
                        state <= S_ACK;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                S_ACK:   state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    assign on_bus = (state == S_LEAD) || (state == S_ACT) || (state == S_TRAIL);

    for (genvar z = 0; z < NZ; z++) begin : g_cs
        assign cs_n[z] = !(on_bus && (cur_zone == ZW'(z)));
    end

    assign rd_n       = !((state == S_ACT) && !cur_write);
    assign wr_n       = !((state == S_ACT) && cur_write);
    assign bus_oe     = on_bus && cur_write;
    assign bus_dout   = wdata_q;
    assign ack        = (state == S_ACK);
    assign host_rdata = rdata_q;
    assign err        = err_q;

    // R3: never more than one zone selected
    a_r3_cs_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));

    // R3: a strobe only appears inside a chip-select window
    a_r3_strobe_in_cs: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n) |-> (cs_n != '1));

    // R4: read and write strobes are exclusive
    a_r4_no_dual_strobe: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

    // R10: acknowledge is a single cycle with the bus released
    a_r10_ack_pulse: assert property (@(posedge clk) disable iff (rst)
        ack |-> (cs_n == '1) ##1 !ack);

    // R10: a held request does not retarget an access in flight
    a_r10_hold_zone: assert property (@(posedge clk) disable iff (rst)
        (state != S_IDLE) |=> $stable(cur_zone));

    // R9: the wait-state budget always ends the active phase
    a_r9_wait_cap: assert property (@(posedge clk) disable iff (rst)
        (state == S_ACT && cnt == '0 && wait_cnt == WAIT_W'(WAIT_MAX)) |=> (state == S_TRAIL));

    // R6: an accepted write never carries a lead below the minimum
    a_r6_lead_min: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && req_valid && req_write) |=> (plan_q.lead >= CNT_W'(WR_LEAD_MIN)));
endmodule

// File: rtl/ebus_seq.sv
`timescale 1ns/1ps
module ebus_seq import ebus_pkg::*; #(
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [ZW-1:0]    req_zone,
    input  logic [DW-1:0]    req_wdata,
    output logic             ack,
    output logic [DW-1:0]    host_rdata,
    output logic [2:0]       err_flags,
    output logic [NZ-1:0]    bus_cs_n,
    output logic             bus_rd_n,
    output logic             bus_wr_n,
    output logic             bus_oe,
    output logic [DW-1:0]    bus_dout,
    input  logic [DW-1:0]    bus_din,
    input  logic             bus_ready
);
    zone_cfg_t   sel_cfg;
    bank_cfg_t   bank;
    phase_plan_t plan;
    cfg_err_t    plan_err;
    cfg_err_t    err;

    ebus_cfg_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .sel_zone  (req_zone),
        .sel_cfg   (sel_cfg),
        .bank      (bank)
    );

    ebus_phase_calc u_calc (
        .cfg      (sel_cfg),
        .is_write (req_write),
        .rdy_en   (bank.rdy_en[req_zone]),
        .plan     (plan),
        .err      (plan_err)
    );

    ebus_phase_fsm #(.DW(DW)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_zone   (req_zone),
        .req_wdata  (req_wdata),
        .plan       (plan),
        .plan_err   (plan_err),
        .bank_zone  (bank.zone),
        .bank_gap   (bank.gap),
        .bus_ready  (bus_ready),
        .bus_din    (bus_din),
        .ack        (ack),
        .host_rdata (host_rdata),
        .err        (err),
        .cs_n       (bus_cs_n),
        .rd_n       (bus_rd_n),
        .wr_n       (bus_wr_n),
        .bus_oe     (bus_oe),
        .bus_dout   (bus_dout)
    );

    assign err_flags = err;
endmodule

// File: tb/ebus_seq_test.sv
`timescale 1ns/1ps
module ebus_seq_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [3:0]  cfg_addr;
    logic [15:0] cfg_wdata;
    logic        req_valid;
    logic        req_write;
    logic [2:0]  req_zone;
    logic [15:0] req_wdata;
    logic        ack;
    logic [15:0] host_rdata;
    logic [2:0]  err_flags;
    logic [7:0]  bus_cs_n;
    logic        bus_rd_n;
    logic        bus_wr_n;
    logic        bus_oe;
    logic [15:0] bus_dout;
    logic [15:0] bus_din;
    logic        bus_ready;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    int a_gap, a_lead, a_act, a_trail, a_bad;
    logic [15:0] a_rd;
    logic [2:0]  a_err;

    always #2.5 clk = ~clk;

    ebus_seq uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_write(req_write), .req_zone(req_zone), .req_wdata(req_wdata),
        .ack(ack), .host_rdata(host_rdata), .err_flags(err_flags),
        .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_oe(bus_oe), .bus_dout(bus_dout), .bus_din(bus_din), .bus_ready(bus_ready)
    );

    // {write, zone, timing word, lead, active, trail, err, pad}
    localparam logic [39:0] VEC [8] = '{
        {1'b0, 3'd0, 16'h7259, 4'd2, 4'd7, 4'd1, 3'b000, 5'd0},
        {1'b0, 3'd1, 16'h720C, 4'd1, 4'd6, 4'd1, 3'b001, 5'd0},
        {1'b0, 3'd2, 16'h72FF, 4'd7, 4'd8, 4'd3, 3'b000, 5'd0},
        {1'b1, 3'd3, 16'h72FF, 4'd3, 4'd4, 4'd2, 3'b000, 5'd0},
        {1'b1, 3'd4, 16'h20FF, 4'd3, 4'd1, 4'd1, 3'b110, 5'd0},
        {1'b1, 3'd5, 16'hFFFF, 4'd7, 4'd7, 4'd3, 3'b000, 5'd0},
        {1'b0, 3'd6, 16'hFF36, 4'd1, 4'd6, 4'd2, 3'b000, 5'd0},
        {1'b1, 3'd6, 16'hFF36, 4'd7, 4'd7, 4'd3, 3'b000, 5'd0}
    };

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic cfg_write(input logic [3:0] addr, input logic [15:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = addr; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // request held until acknowledge; phases measured at each falling edge
    task automatic access(input logic wr, input logic [2:0] zone, input logic [15:0] wd);
        int cycles;
        bit done;
        logic [7:0] cs_exp;
        cs_exp = ~(8'd1 << zone);
        a_gap = 0; a_lead = 0; a_act = 0; a_trail = 0; a_bad = 0;
        cycles = 0; done = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_zone = zone; req_wdata = wd;
        @(negedge clk);
        while (!done && cycles < 200) begin
            if (ack) begin
                done  = 1;
                a_rd  = host_rdata;
                a_err = err_flags;
                if (bus_cs_n != 8'hFF) a_bad++;
                req_valid = 1'b0;
            end else if (bus_cs_n == 8'hFF) begin
                if (a_lead != 0) a_bad++;
                a_gap++;
            end else begin
                if (bus_cs_n != cs_exp) a_bad++;
                if (!bus_rd_n || !bus_wr_n) begin
                    a_act++;
                    if (bus_rd_n == wr ? 1'b0 : 1'b1) a_bad++;
                end else if (a_act == 0) a_lead++;
                else a_trail++;
                if (bus_oe != wr) a_bad++;
                if (wr && bus_dout != wd) a_bad++;
            end
            if (!done) begin
                cycles++;
                @(negedge clk);
            end
        end
        req_valid = 1'b0;
        chk("R10 acknowledge seen", int'(done), 1);
        @(negedge clk);
        chk("R10 acknowledge single cycle", int'(ack), 0);
        chk("R10 bus idle after acknowledge", int'(bus_cs_n), 255);
    endtask

    task automatic expect_phases(input string tag, input int g, input int l, input int a, input int t);
        chk({tag, " idle gap"}, a_gap, g);
        chk({tag, " lead"}, a_lead, l);
        chk({tag, " active"}, a_act, a);
        chk({tag, " trail"}, a_trail, t);
        chk({tag, " strobe/cs/data per cycle R4"}, a_bad, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        req_valid = 1'b0; req_write = 1'b0; req_zone = '0; req_wdata = '0;
        bus_din = '0; bus_ready = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle outputs after reset
        chk("R1 chip selects", int'(bus_cs_n), 255);
        chk("R1 read strobe", int'(bus_rd_n), 1);
        chk("R1 write strobe", int'(bus_wr_n), 1);
        chk("R1 ack", int'(ack), 0);
        chk("R1 err", int'(err_flags), 0);
        chk("R1 oe", int'(bus_oe), 0);

        // R1: default timing word all ones, first access has no history
        bus_din = 16'h5A3C;
        access(1'b0, 3'd7, 16'h0);
        expect_phases("R1 default zone 7 read", 0, 7, 8, 3);
        chk("R8 read data", int'(a_rd), 16'h5A3C);
        // R1/R11: default bank zone 7 with idle count 3
        access(1'b0, 3'd0, 16'h0);
        expect_phases("R11 leave default bank zone", 3, 7, 8, 3);

        // table of R2..R7, R13 vectors across zones 0..6 (no bank zone)
        for (int i = 0; i < 8; i++) begin
            logic [39:0] v;
            v = VEC[i];
            cfg_write({1'b0, v[38:36]}, v[35:20]);
            bus_din = 16'h1000 + 16'(i);
            access(v[39], v[38:36], 16'hB000 + 16'(i));
            expect_phases("R2 R3 R4 R12 vector", 0, int'(v[19:16]), int'(v[15:12]), int'(v[11:8]));
            chk("R5 R6 R7 R13 err flags", int'(a_err), int'(v[7:5]));
            if (!v[39]) chk("R8 read data", int'(a_rd), 16'h1000 + i);
        end

        // R12: repeats and moves from a non-bank zone add nothing
        access(1'b0, 3'd7, 16'h0);
        expect_phases("R12 into bank zone", 0, 7, 8, 3);
        access(1'b0, 3'd7, 16'h0);
        expect_phases("R12 repeat bank zone", 0, 7, 8, 3);
        access(1'b0, 3'd1, 16'h0);
        expect_phases("R11 bank zone to zone 1", 3, 1, 6, 1);

        // R11: bank zone 2, idle count 5
        cfg_write(4'd8, 16'h002A);
        access(1'b0, 3'd2, 16'h0);
        expect_phases("R12 into new bank zone", 0, 7, 8, 3);
        access(1'b1, 3'd3, 16'hC0DE);
        expect_phases("R11 gap 5 on leaving", 5, 3, 4, 2);
        access(1'b1, 3'd2, 16'hC0DF);
        expect_phases("R12 from zone 3", 0, 3, 4, 2);

        // R12: idle count 0 gives no gap
        cfg_write(4'd8, 16'h0002);
        access(1'b0, 3'd3, 16'h0);
        expect_phases("R12 zero idle count", 0, 7, 8, 3);

        // R9: zone 1 ready-enabled, ready held low -> 7 wait states
        cfg_write(4'd8, 16'h0082);
        bus_ready = 1'b0;
        bus_din = 16'h7E57;
        access(1'b0, 3'd1, 16'h0);
        expect_phases("R9 read capped waits", 0, 1, 13, 1);
        chk("R8 read data after waits", int'(a_rd), 16'h7E57);
        access(1'b1, 3'd1, 16'h9999);
        expect_phases("R9 write capped waits", 0, 3, 11, 2);
        access(1'b0, 3'd0, 16'h0);
        expect_phases("R9 ready ignored on zone 0", 0, 2, 7, 1);
        bus_ready = 1'b1;
        access(1'b0, 3'd1, 16'h0);
        expect_phases("R9 ready high no waits", 0, 1, 6, 1);
        chk("R13 err refreshed", int'(a_err), 1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule